// File: doc/BRIEF.md
# Out-of-Order Operation Dispatch Station

This block buffers operations that have already been renamed and sends them to execution out of program order. It feeds two ALUs and one load/store port. Each cycle the front end can offer up to two operations on two insertion lanes. Every operation carries an opcode payload, a destination tag and two source tags, and each source tag has a flag that says whether its value already exists. The station keeps each operation until both of its sources are available. A source becomes available when a writeback broadcast on the result bus matches its tag. Among the operations that are ready, the station picks the oldest ones for each kind of unit and sends them out on registered issue ports.

There is no forwarding path. A writeback is recorded in the station at one clock edge. An operation that depends on it can be selected only in the cycle that follows that edge. The whole station empties when a flush occurs. The front end learns through a ready signal whether an offer will be taken.

Top module: `rs_dispatch`

## Requirements
- R1: After reset all three issue valids are low, and an empty station shows `in_ready` high even when both lanes offer.
- R2: An operation inserted at clock edge E with both sources available appears on its issue port after edge E+1. The port carries that operation's opcode and destination tag.
- R3: `in_ready` is low when fewer entries are free than the number of lanes with `in_valid` set. A refused operation is never stored and never issues. An entry freed by an issue becomes available for insertion only from the next cycle on.
- R4: An operation that waits on a tag issues no earlier than the second clock edge after the edge at which `wb_valid` carries that tag. Until then it does not issue.
- R5: If an incoming source tag matches the writeback tag presented in the same cycle, that source is marked available at insertion.
- R6: When more than two ALU operations are ready, the two oldest by insertion order issue first. Within one cycle, lane 0 counts as older than lane 1.
- R7: The two ALU grants in a cycle go to different entries. Port 0 (`alu0_*`) gets the older one. `alu1_valid` is never high while `alu0_valid` is low.
- R8: An operation whose class bit (`in_is_mem` = 1) marks it as memory goes only to the memory port, one per cycle, oldest first. A class bit of 0 marks an ALU operation, which goes only to the ALU ports.
- R9: While `flush` is high, `in_ready` is low and offered operations are dropped. After the flush edge the station is empty and all issue valids are low.
- R10: A ready operation issues ahead of an older operation that is still waiting.
- R11: Each stored operation issues exactly once and leaves the station at its issue edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the station; takes priority over insertion |
| in_valid | input | 2 | Per-lane offer valid |
| in_is_mem | input | 2 | Per-lane class, 1 = memory, 0 = ALU |
| in_op | input | 2*OP_W | Per-lane opcode payload, lane k at [k*OP_W +: OP_W] |
| in_dst | input | 2*TAG_W | Per-lane destination tag |
| in_src0 | input | 2*TAG_W | Per-lane first source tag |
| in_src0_rdy | input | 2 | First source already available |
| in_src1 | input | 2*TAG_W | Per-lane second source tag |
| in_src1_rdy | input | 2 | Second source already available |
| in_ready | output | 1 | Offer accepted this cycle |
| wb_valid | input | 1 | Writeback broadcast valid |
| wb_tag | input | TAG_W | Writeback tag |
| alu0_valid | output | 1 | ALU port 0 issue valid |
| alu0_op | output | OP_W | ALU port 0 opcode |
| alu0_dst | output | TAG_W | ALU port 0 destination tag |
| alu1_valid | output | 1 | ALU port 1 issue valid |
| alu1_op | output | OP_W | ALU port 1 opcode |
| alu1_dst | output | TAG_W | ALU port 1 destination tag |
| mem_valid | output | 1 | Memory port issue valid |
| mem_op | output | OP_W | Memory port opcode |
| mem_dst | output | TAG_W | Memory port destination tag |

## Verification
Three pairs of events can land on the same clock edge, and each pair is set up on purpose. The first pair is insertion and writeback. An operation is offered whose source tag equals the tag being broadcast in that same cycle, and it must then issue on the normal schedule rather than hang. The second pair is flush and insertion. A ready operation is offered in the flush cycle, and the bench watches the ports for several cycles to confirm that nothing ever issues. The third pair is flush and a pending issue. The flush is raised in the very cycle in which a selected operation would be registered, and the issue port must stay low.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int LANES = 2;

  typedef enum logic {
    CLS_ALU = 1'b0,
    CLS_MEM = 1'b1
  } op_class_e;
endpackage

// File: rtl/rs_alloc.sv
// Finds free slots for the two insertion lanes and decides acceptance.
module rs_alloc #(
  parameter int N = 8
) (
  input  logic [N-1:0] busy,
  input  logic [1:0]   offer,
  input  logic         flush,
  output logic [N-1:0] slot0,
  output logic [N-1:0] slot1,
  output logic         accept
);
  localparam int CNT_W = $clog2(N + 1);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]     free_v, first_oh, rest, second_oh;
  logic [CNT_W-1:0] free_cnt, want;

  assign free_v    = ~busy;
  assign first_oh  = free_v & (~free_v + ONE);
  assign rest      = free_v & ~first_oh;
  assign second_oh = rest & (~rest + ONE);

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < N; i++) free_cnt = free_cnt + CNT_W'(free_v[i]);
  end

  assign want   = CNT_W'(offer[0]) + CNT_W'(offer[1]);
  assign accept = !flush && (free_cnt >= want);

  always_comb begin
    slot0 = '0;
    slot1 = '0;
    if (accept) begin
      if (offer[0]) slot0 = first_oh;
      if (offer[1]) slot1 = offer[0] ? second_oh : first_oh;
    end
  end
endmodule

// File: rtl/rs_pick.sv
// Oldest-first grant: older[i][j] set means entry j is older than entry i.
module rs_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]        req,
  input  logic [N-1:0][N-1:0] older,
  output logic [N-1:0]        gnt
);
  for (genvar i = 0; i < N; i++) begin : g_row
    assign gnt[i] = req[i] && !(|(req & older[i]));
  end
endmodule

// File: rtl/rs_dispatch.sv
module rs_dispatch
  import rs_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int OP_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic [1:0]              in_valid,
  input  logic [1:0]              in_is_mem,
  input  logic [2*OP_W-1:0]       in_op,
  input  logic [2*TAG_W-1:0]      in_dst,
  input  logic [2*TAG_W-1:0]      in_src0,
  input  logic [1:0]              in_src0_rdy,
  input  logic [2*TAG_W-1:0]      in_src1,
  input  logic [1:0]              in_src1_rdy,
  output logic                    in_ready,
  input  logic                    wb_valid,
  input  logic [TAG_W-1:0]        wb_tag,
  output logic                    alu0_valid,
  output logic [OP_W-1:0]         alu0_op,
  output logic [TAG_W-1:0]        alu0_dst,
  output logic                    alu1_valid,
  output logic [OP_W-1:0]         alu1_op,
  output logic [TAG_W-1:0]        alu1_dst,
  output logic                    mem_valid,
  output logic [OP_W-1:0]         mem_op,
  output logic [TAG_W-1:0]        mem_dst
);
  localparam int N = ENTRIES;

  // Entry storage
  logic [N-1:0]          vld_q, r0_q, r1_q;
  op_class_e             cls_q [N];
  logic [OP_W-1:0]       op_q  [N];
  logic [TAG_W-1:0]      dst_q [N];
  logic [TAG_W-1:0]      s0_q  [N];
  logic [TAG_W-1:0]      s1_q  [N];
  logic [N-1:0][N-1:0]   older_q;

  // Lane decode
  logic [OP_W-1:0]  l_op  [LANES];
  logic [TAG_W-1:0] l_dst [LANES];
  logic [TAG_W-1:0] l_s0  [LANES];
  logic [TAG_W-1:0] l_s1  [LANES];
  logic [LANES-1:0] l_r0, l_r1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign l_op[k]  = in_op[k*OP_W +: OP_W];
    assign l_dst[k] = in_dst[k*TAG_W +: TAG_W];
    assign l_s0[k]  = in_src0[k*TAG_W +: TAG_W];
    assign l_s1[k]  = in_src1[k*TAG_W +: TAG_W];
    assign l_r0[k]  = in_src0_rdy[k] | (wb_valid && (l_s0[k] == wb_tag));
    assign l_r1[k]  = in_src1_rdy[k] | (wb_valid && (l_s1[k] == wb_tag));
  end

  // Wakeup compare per entry
  logic [N-1:0] hit0, hit1, is_mem;
  for (genvar i = 0; i < N; i++) begin : g_wake
    assign hit0[i]   = wb_valid && (s0_q[i] == wb_tag);
    assign hit1[i]   = wb_valid && (s1_q[i] == wb_tag);
    assign is_mem[i] = (cls_q[i] == CLS_MEM);
  end

  // Allocation
  logic [N-1:0] alloc0, alloc1, alloc_any;
  rs_alloc #(.N(N)) u_alloc (
    .busy  (vld_q),
    .offer (in_valid),
    .flush (flush),
    .slot0 (alloc0),
    .slot1 (alloc1),
    .accept(in_ready)
  );
  assign alloc_any = alloc0 | alloc1;

  // Selection
  logic [N-1:0] rdy_v, alu_req, alu_req1, mem_req;
  logic [N-1:0] g_alu0, g_alu1, g_mem, gnt_any, keep_row;

  assign rdy_v    = vld_q & r0_q & r1_q;
  assign alu_req  = rdy_v & ~is_mem;
  assign mem_req  = rdy_v & is_mem;
  assign alu_req1 = alu_req & ~g_alu0;

  rs_pick #(.N(N)) u_pick_alu0 (.req(alu_req),  .older(older_q), .gnt(g_alu0));
  rs_pick #(.N(N)) u_pick_alu1 (.req(alu_req1), .older(older_q), .gnt(g_alu1));
  rs_pick #(.N(N)) u_pick_mem  (.req(mem_req),  .older(older_q), .gnt(g_mem));

  assign gnt_any  = g_alu0 | g_alu1 | g_mem;
  assign keep_row = vld_q & ~gnt_any;

  // Valid bits
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_any[i])    vld_q[i] <= 1'b1;
        else if (gnt_any[i]) vld_q[i] <= 1'b0;
      end
    end
  end

  // Entry fields, readiness and age rows
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (alloc0[i]) begin
        cls_q[i]   <= in_is_mem[0] ? CLS_MEM : CLS_ALU;
        op_q[i]    <= l_op[0];
        dst_q[i]   <= l_dst[0];
        s0_q[i]    <= l_s0[0];
        s1_q[i]    <= l_s1[0];
        r0_q[i]    <= l_r0[0];
        r1_q[i]    <= l_r1[0];
        older_q[i] <= keep_row;
      end else if (alloc1[i]) begin
        cls_q[i]   <= in_is_mem[1] ? CLS_MEM : CLS_ALU;
        op_q[i]    <= l_op[1];
        dst_q[i]   <= l_dst[1];
        s0_q[i]    <= l_s0[1];
        s1_q[i]    <= l_s1[1];
        r0_q[i]    <= l_r0[1];
        r1_q[i]    <= l_r1[1];
        older_q[i] <= keep_row | alloc0;
      end else begin
        if (hit0[i]) r0_q[i] <= 1'b1;
        if (hit1[i]) r1_q[i] <= 1'b1;
        older_q[i] <= older_q[i] & ~alloc_any;
      end
    end
  end

  // Payload muxes
  logic [OP_W-1:0]  a0_op, a1_op, m_op;
  logic [TAG_W-1:0] a0_dst, a1_dst, m_dst;
  always_comb begin
    a0_op = '0; a1_op = '0; m_op = '0;
    a0_dst = '0; a1_dst = '0; m_dst = '0;
    for (int i = 0; i < N; i++) begin
      if (g_alu0[i]) begin a0_op |= op_q[i]; a0_dst |= dst_q[i]; end
      if (g_alu1[i]) begin a1_op |= op_q[i]; a1_dst |= dst_q[i]; end
      if (g_mem[i])  begin m_op  |= op_q[i]; m_dst  |= dst_q[i]; end
    end
  end

  // Registered issue ports
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      alu0_valid <= 1'b0;
      alu1_valid <= 1'b0;
      mem_valid  <= 1'b0;
    end else begin
      alu0_valid <= |g_alu0;
      alu1_valid <= |g_alu1;
      mem_valid  <= |g_mem;
    end
    alu0_op  <= a0_op;
    alu0_dst <= a0_dst;
    alu1_op  <= a1_op;
    alu1_dst <= a1_dst;
    mem_op   <= m_op;
    mem_dst  <= m_dst;
  end
endmodule

// File: rtl/rs_dispatch_chk.sv
module rs_dispatch_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         flush,
  input logic         in_ready,
  input logic [1:0]   in_valid,
  input logic [N-1:0] vld_q,
  input logic [N-1:0] is_mem,
  input logic [N-1:0] g_alu0,
  input logic [N-1:0] g_alu1,
  input logic [N-1:0] g_mem,
  input logic         alu0_valid,
  input logic         alu1_valid,
  input logic         mem_valid
);
  assert_alu_distinct_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(g_alu0) && $onehot0(g_alu1) && ((g_alu0 & g_alu1) == '0));

  assert_port_order_R7: assert property (@(posedge clk) disable iff (rst)
    alu1_valid |-> alu0_valid);

  assert_class_route_R8: assert property (@(posedge clk) disable iff (rst)
    (((g_alu0 | g_alu1) & is_mem) == '0) && ((g_mem & ~is_mem) == '0) && $onehot0(g_mem));

  assert_grant_live_R2: assert property (@(posedge clk) disable iff (rst)
    ((g_alu0 | g_alu1 | g_mem) & ~vld_q) == '0);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (($countones(vld_q) + $countones(in_valid)) <= N));

  assert_flush_refuses_R9: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0) && !alu0_valid && !alu1_valid && !mem_valid);

  assert_issue_once_R11: assert property (@(posedge clk) disable iff (rst)
    ((g_alu0 | g_alu1 | g_mem) != '0) |=> ((($past(g_alu0 | g_alu1 | g_mem)) & vld_q) == '0));
endmodule

bind rs_dispatch rs_dispatch_chk #(.N(ENTRIES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .in_ready  (in_ready),
  .in_valid  (in_valid),
  .vld_q     (vld_q),
  .is_mem    (is_mem),
  .g_alu0    (g_alu0),
  .g_alu1    (g_alu1),
  .g_mem     (g_mem),
  .alu0_valid(alu0_valid),
  .alu1_valid(alu1_valid),
  .mem_valid (mem_valid)
);

// File: tb/rs_dispatch_test.sv
module rs_dispatch_test;
  localparam int N = 8, TW = 6, OW = 8;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic [1:0] in_valid = '0, in_is_mem = '0, in_src0_rdy = '0, in_src1_rdy = '0;
  logic [2*OW-1:0] in_op = '0;
  logic [2*TW-1:0] in_dst = '0, in_src0 = '0, in_src1 = '0;
  logic in_ready, wb_valid = 1'b0;
  logic [TW-1:0] wb_tag = '0;
  logic alu0_valid, alu1_valid, mem_valid;
  logic [OW-1:0] alu0_op, alu1_op, mem_op;
  logic [TW-1:0] alu0_dst, alu1_dst, mem_dst;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  rs_dispatch #(.ENTRIES(N), .TAG_W(TW), .OP_W(OW)) uut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_is_mem(in_is_mem),
    .in_op(in_op), .in_dst(in_dst), .in_src0(in_src0), .in_src0_rdy(in_src0_rdy),
    .in_src1(in_src1), .in_src1_rdy(in_src1_rdy), .in_ready(in_ready),
    .wb_valid(wb_valid), .wb_tag(wb_tag),
    .alu0_valid(alu0_valid), .alu0_op(alu0_op), .alu0_dst(alu0_dst),
    .alu1_valid(alu1_valid), .alu1_op(alu1_op), .alu1_dst(alu1_dst),
    .mem_valid(mem_valid), .mem_op(mem_op), .mem_dst(mem_dst)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = '0; wb_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic lane(input int k, input bit mem, input int op, input int dst,
                      input int s0, input bit r0, input int s1, input bit r1);
    in_is_mem[k]           = mem;
    in_op[k*OW +: OW]      = OW'(op);
    in_dst[k*TW +: TW]     = TW'(dst);
    in_src0[k*TW +: TW]    = TW'(s0);
    in_src0_rdy[k]         = r0;
    in_src1[k*TW +: TW]    = TW'(s1);
    in_src1_rdy[k]         = r1;
  endtask

  task automatic wb(input int tag);
    wb_valid = 1'b1; wb_tag = TW'(tag);
  endtask

  task automatic t_reset();
    step();
    chk("R1 alu0", alu0_valid, 0);
    chk("R1 alu1", alu1_valid, 0);
    chk("R1 mem", mem_valid, 0);
    in_valid = 2'b11; #1;
    chk("R1 ready empty", in_ready, 1);
    in_valid = 2'b00;
  endtask

  task automatic t_basic();
    step();
    lane(0, 0, 'h11, 5, 1, 1, 2, 1);
    lane(1, 1, 'h22, 6, 1, 1, 2, 1);
    in_valid = 2'b11;
    step(); idle();
    chk("R2 not yet", alu0_valid | mem_valid, 0);
    step();
    chk("R2 alu0 valid", alu0_valid, 1);
    chk("R2 alu0 op", alu0_op, 'h11);
    chk("R2 alu0 dst", alu0_dst, 5);
    chk("R8 mem op", mem_valid ? mem_op : 0, 'h22);
    chk("R2 alu1 idle", alu1_valid, 0);
    step();
    chk("R11 once", alu0_valid | mem_valid | alu1_valid, 0);
  endtask

  task automatic t_wakeup();
    step();
    lane(0, 0, 'h31, 7, 9, 0, 1, 1);
    in_valid = 2'b01;
    step(); idle();
    step(); step();
    chk("R4 waiting", alu0_valid, 0);
    wb(9);
    step(); idle();
    chk("R4 no bypass", alu0_valid, 0);
    step();
    chk("R4 woken", alu0_valid ? alu0_op : 0, 'h31);
    step();
    chk("R11 woken once", alu0_valid, 0);
  endtask

  task automatic t_insert_wb();
    step();
    lane(0, 0, 'h41, 8, 12, 0, 3, 1);
    in_valid = 2'b01;
    wb(12);
    step(); idle();
    chk("R5 early", alu0_valid, 0);
    step();
    chk("R5 captured", alu0_valid ? alu0_op : 0, 'h41);
  endtask

  task automatic t_ooo();
    step();
    lane(0, 0, 'h51, 20, 30, 0, 1, 1);
    lane(1, 0, 'h52, 21, 1, 1, 1, 1);
    in_valid = 2'b11;
    step();
    lane(0, 0, 'h53, 22, 1, 1, 1, 1);
    lane(1, 0, 'h54, 23, 1, 1, 1, 1);
    in_valid = 2'b11;
    chk("R10 none yet", alu0_valid, 0);
    step(); idle();
    chk("R10 younger first", alu0_valid ? alu0_op : 0, 'h52);
    chk("R10 one grant", alu1_valid, 0);
    step();
    chk("R7 alu0 older", alu0_valid ? alu0_op : 0, 'h53);
    chk("R7 alu1 younger", alu1_valid ? alu1_op : 0, 'h54);
    wb(30);
    step(); idle();
    chk("R4 waiter held", alu0_valid, 0);
    step();
    chk("R4 waiter issues", alu0_valid ? alu0_op : 0, 'h51);
  endtask

  task automatic t_oldest();
    step();
    lane(0, 0, 'h61, 24, 40, 0, 1, 1);
    lane(1, 0, 'h62, 25, 40, 0, 1, 1);
    in_valid = 2'b11;
    step();
    lane(0, 0, 'h63, 26, 40, 0, 1, 1);
    in_valid = 2'b01;
    step(); idle();
    wb(40);
    step(); idle();
    chk("R6 held", alu0_valid, 0);
    step();
    chk("R6 first", alu0_valid ? alu0_op : 0, 'h61);
    chk("R6 second", alu1_valid ? alu1_op : 0, 'h62);
    step();
    chk("R6 third", alu0_valid ? alu0_op : 0, 'h63);
    chk("R6 third alone", alu1_valid, 0);
  endtask

  task automatic t_mem();
    step();
    lane(0, 1, 'h71, 27, 1, 1, 41, 0);
    lane(1, 1, 'h72, 28, 1, 1, 41, 0);
    in_valid = 2'b11;
    step(); idle();
    wb(41);
    step(); idle();
    chk("R8 held", mem_valid, 0);
    step();
    chk("R8 oldest mem", mem_valid ? mem_op : 0, 'h71);
    chk("R8 not on alu", alu0_valid | alu1_valid, 0);
    step();
    chk("R8 next mem", mem_valid ? mem_op : 0, 'h72);
  endtask

  task automatic t_flush();
    int seen = 0;
    step();
    lane(0, 0, 'h80, 29, 42, 0, 1, 1);
    in_valid = 2'b01;
    step();
    lane(0, 0, 'h81, 30, 1, 1, 1, 1);
    in_valid = 2'b01;
    flush = 1'b1; #1;
    chk("R9 refused", in_ready, 0);
    step(); idle();
    wb(42);
    for (int c = 0; c < 4; c++) begin
      step(); idle();
      seen += int'(alu0_valid) + int'(alu1_valid) + int'(mem_valid);
    end
    chk("R9 emptied", seen, 0);
    lane(0, 0, 'h82, 31, 1, 1, 1, 1);
    in_valid = 2'b01;
    step(); idle();
    flush = 1'b1;
    step(); idle();
    chk("R9 kills issue", alu0_valid, 0);
    step();
    chk("R9 stays gone", alu0_valid, 0);
  endtask

  task automatic t_full();
    int cnt = 0, bad = 0;
    for (int p = 0; p < 3; p++) begin
      step();
      lane(0, 0, 'h90 + 2*p, 32 + 2*p, 43, 0, 1, 1);
      lane(1, 0, 'h91 + 2*p, 33 + 2*p, 43, 0, 1, 1);
      in_valid = 2'b11; #1;
      chk("R3 room", in_ready, 1);
    end
    step();
    lane(0, 0, 'h96, 38, 43, 0, 1, 1);
    in_valid = 2'b01;
    step();
    lane(0, 0, 'h97, 39, 43, 0, 1, 1);
    lane(1, 0, 'h98, 40, 43, 0, 1, 1);
    in_valid = 2'b11; #1;
    chk("R3 two vs one free", in_ready, 0);
    in_valid = 2'b01; #1;
    chk("R3 one vs one free", in_ready, 1);
    step();
    lane(0, 0, 'h9F, 41, 1, 1, 1, 1);
    in_valid = 2'b01; #1;
    chk("R3 full", in_ready, 0);
    step(); idle();
    wb(43);
    for (int c = 0; c < 7; c++) begin
      step(); idle();
      cnt += int'(alu0_valid) + int'(alu1_valid);
      if ((alu0_valid && alu0_op == 8'h9F) || (alu1_valid && alu1_op == 8'h9F)) bad++;
    end
    chk("R3 refused never issues", bad, 0);
    chk("R11 all stored issue once", cnt, 8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_wakeup();
    t_insert_wb();
    t_ooo();
    t_oldest();
    t_mem();
    t_flush();
    t_full();
    step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule